// File: doc/BRIEF.md
# Double-Buffered DAC Bus Write Sequencer

This block sits on the processor side of an 8-bit data bus and delivers 10-bit samples to a converter that has an input latch and a separate output register. A sample arrives with a valid/ready handshake. The block splits it into two left-justified byte writes: the upper eight bits first, then the two low bits placed at the top of the second byte. Each write drives the chip select, the low address bit (which doubles as the byte selector) and an active-low write strobe. Setup, pulse width and hold are counted in system clock cycles.

Moving data from the input latch to the output register is controlled by a transfer strobe. One of three transfer policies is chosen for each word:
- In automatic mode, the transfer strobe fires together with the second write.
- In shared-strobe mode, the two writes only fill the latch. A third write cycle, on a separate transfer select, then drives a transfer line that many converters can share.
- In external mode, the block waits for an update strobe from outside and then emits the transfer pulse. An update strobe that comes early is remembered.

The block accepts a new word only once the whole sequence, transfer included, has ended.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, `ready_o` is high and `cs_n_o`, `xfer_cs_n_o`, `wr_n_o` and `xfer_n_o` are all high.
- R2: The first write carries `word[9:2]` with `addr0_o`=0 and `bsel_o`=1. The second write carries `{word[1:0],6'b0}` with `addr0_o`=1 and `bsel_o`=0.
- R3: Each write strobe stays low for exactly PULSE_CYC cycles. Data and select are stable for at least SETUP_CYC cycles before the strobe falls, and they remain unchanged during the first cycle after it rises.
- R4: With `mode_i`=0 (and also with 3, which is treated the same), exactly two writes are made. `xfer_n_o` is low exactly while the second write strobe is low.
- R5: With `mode_i`=1, the two data writes use `cs_n_o` low and keep `xfer_n_o` high. A third write follows with `xfer_cs_n_o` low, `cs_n_o` high and `xfer_n_o` low while the write strobe is low. The two selects are never low together.
- R6: With `mode_i`=2, after the two writes `xfer_n_o` stays high until a rising edge on `ext_upd_i`. It then goes low for exactly PULSE_CYC cycles while `wr_n_o` stays high.
- R7: In mode 2, a rising edge on `ext_upd_i` that arrives while the bytes are still being written is kept. The transfer pulse follows the second write without any further strobe.
- R8: `ready_o` is low from the accepting edge until the transfer of that word has ended. The word and mode are captured at the handshake, so later changes on `word_i` have no effect. A word held valid back to back starts only after the previous transfer.
- R9: A rising edge on `ext_upd_i` while the block is idle is discarded. A following mode-2 word still waits for a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 10 | Sample to send |
| mode_i | input | 2 | Transfer policy: 0 automatic, 1 shared strobe, 2 external, 3 as 0 |
| valid_i | input | 1 | Word present |
| ready_o | output | 1 | Block idle, word accepted on this edge if valid |
| ext_upd_i | input | 1 | External update strobe, rising edge active |
| data_o | output | 8 | Bus data byte |
| addr0_o | output | 1 | Low address bit, 0 first byte, 1 second byte |
| bsel_o | output | 1 | Byte selector, high on first byte, low on second |
| cs_n_o | output | 1 | Converter data chip select, active low |
| xfer_cs_n_o | output | 1 | Shared transfer-strobe select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| xfer_n_o | output | 1 | Transfer strobe to output register, active low |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3 and HOLD_CYC=1. With these values, a strobe width of one cycle or a missing setup cycle shows up as a wrong count, and a single hold cycle makes a byte change that comes one cycle early visible. Because the width is three cycles, the early external strobe can be placed in the middle of the first write. The long wait in external mode checks that nothing fires without the strobe.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_WAIT} st_e;
  typedef enum logic [1:0] {PH_HI, PH_LO, PH_XF} ph_e;
  typedef enum logic [1:0] {XM_AUTO, XM_PROC, XM_EXT} xm_e;

  function automatic xm_e decode_mode(input logic [1:0] m);
    case (m)
      2'd1:    return XM_PROC;
      2'd2:    return XM_EXT;
      default: return XM_AUTO;
    endcase
  endfunction
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_byte_fmt.sv
module dac_byte_fmt #(
  parameter int DW = 10,
  parameter int BW = 8
) (
  input  logic [DW-1:0] word_i,
  output logic [BW-1:0] hi_o,
  output logic [BW-1:0] lo_o
);
  localparam int LOW_BITS = DW - BW;

  assign hi_o = word_i[DW-1 -: BW];

  // left-justified remainder: low bits at the top of the second byte
  generate
    if (LOW_BITS == BW) begin : g_full
      assign lo_o = word_i[LOW_BITS-1:0];
    end else begin : g_pad
      assign lo_o = {word_i[LOW_BITS-1:0], {(BW-LOW_BITS){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/dac_upd_catch.sv
module dac_upd_catch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic arm_i,
  input  logic take_i,
  output logic pend_o
);
  logic upd_q, pend_q;
  logic rise;

  assign rise = upd_i & ~upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      upd_q <= upd_i;
      if (take_i || !arm_i) pend_q <= 1'b0;
      else if (rise)        pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int DW        = 10,
  parameter int BW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] word_i,
  input  logic [1:0]    mode_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          ext_upd_i,
  output logic [BW-1:0] data_o,
  output logic          addr0_o,
  output logic          bsel_o,
  output logic          cs_n_o,
  output logic          xfer_cs_n_o,
  output logic          wr_n_o,
  output logic          xfer_n_o
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_V = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PUL_V = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HLD_V = CW'(HOLD_CYC - 1);

  st_e st_q, st_d;
  ph_e ph_q, ph_d;
  xm_e mode_q;
  logic [DW-1:0] word_q;
  logic          cap, ld, zero, pend, take, arm, busy;
  logic [CW-1:0] ld_val;
  logic [BW-1:0] hi_b, lo_b;

  dac_phase_timer #(.CW(CW)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val), .zero_o(zero)
  );

  dac_byte_fmt #(.DW(DW), .BW(BW)) u_fmt (
    .word_i(word_q), .hi_o(hi_b), .lo_o(lo_b)
  );

  assign arm  = (st_q != ST_IDLE);
  assign take = (st_q == ST_WAIT) && pend;

  dac_upd_catch u_upd (
    .clk_i (clk_i), .rst_ni(rst_ni), .upd_i(ext_upd_i),
    .arm_i (arm), .take_i(take), .pend_o(pend)
  );

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    ld     = 1'b0;
    ld_val = '0;
    cap    = 1'b0;
    case (st_q)
      ST_IDLE: if (valid_i) begin
        cap = 1'b1; st_d = ST_SETUP; ph_d = PH_HI; ld = 1'b1; ld_val = SET_V;
      end
      ST_SETUP: if (zero) begin
        st_d = ST_STROBE; ld = 1'b1; ld_val = PUL_V;
      end
      ST_STROBE: if (zero) begin
        st_d = ST_HOLD; ld = 1'b1; ld_val = HLD_V;
      end
      ST_HOLD: if (zero) begin
        case (ph_q)
          PH_HI: begin
            ph_d = PH_LO; st_d = ST_SETUP; ld = 1'b1; ld_val = SET_V;
          end
          PH_LO: begin
            case (mode_q)
              XM_PROC: begin
                ph_d = PH_XF; st_d = ST_SETUP; ld = 1'b1; ld_val = SET_V;
              end
              XM_EXT:  st_d = ST_WAIT;
              default: st_d = ST_IDLE;
            endcase
          end
          default: st_d = ST_IDLE;
        endcase
      end
      ST_WAIT: if (pend) begin
        ph_d = PH_XF; st_d = ST_STROBE; ld = 1'b1; ld_val = PUL_V;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_HI;
      mode_q <= XM_AUTO;
      word_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (cap) begin
        word_q <= word_i;
        mode_q <= decode_mode(mode_i);
      end
    end
  end

  assign busy        = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
  assign ready_o     = (st_q == ST_IDLE);
  assign cs_n_o      = !(busy && ph_q != PH_XF);
  assign xfer_cs_n_o = !(busy && ph_q == PH_XF && mode_q == XM_PROC);
  assign wr_n_o      = !(st_q == ST_STROBE && !(ph_q == PH_XF && mode_q == XM_EXT));
  assign xfer_n_o    = !(st_q == ST_STROBE &&
                         ((ph_q == PH_LO && mode_q == XM_AUTO) || ph_q == PH_XF));
  assign addr0_o     = (ph_q == PH_LO);
  assign bsel_o      = !addr0_o;
  assign data_o      = (ph_q == PH_HI) ? hi_b : (ph_q == PH_LO) ? lo_b : '0;
endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int BW        = 8,
  parameter int PULSE_CYC = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_o,
  input logic [BW-1:0] data_o,
  input logic          addr0_o,
  input logic          cs_n_o,
  input logic          xfer_cs_n_o,
  input logic          wr_n_o,
  input logic          xfer_n_o
);
  int unsigned wr_lo, xf_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_lo <= 0;
      xf_lo <= 0;
    end else begin
      wr_lo <= wr_n_o ? 0 : wr_lo + 1;
      xf_lo <= xfer_n_o ? 0 : xf_lo + 1;
    end
  end

  p_wr_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_n_o && !$past(wr_n_o)) |-> (wr_lo == PULSE_CYC));

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_n_o)) |-> $stable(data_o));

  p_auto_xfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_n_o && !cs_n_o) |-> (addr0_o && !wr_n_o));

  p_sel_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs_n_o && !xfer_cs_n_o));

  p_xfer_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_n_o && !$past(xfer_n_o)) |-> (xf_lo == PULSE_CYC));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o || !xfer_n_o) |-> !ready_o);

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
endmodule

bind dac_wr_seq dac_wr_seq_chk #(.BW(BW), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .data_o(data_o), .addr0_o(addr0_o), .cs_n_o(cs_n_o), .xfer_cs_n_o(xfer_cs_n_o),
  .wr_n_o(wr_n_o), .xfer_n_o(xfer_n_o)
);

// File: tb/dac_wr_seq_test.sv
module dac_wr_seq_test;
  localparam int SU = 2, PW = 3, HD = 1;

  logic clk_i = 0, rst_ni = 0;
  logic [9:0] word_i = '0;
  logic [1:0] mode_i = '0;
  logic valid_i = 0, ext_upd_i = 0;
  logic ready_o, addr0_o, bsel_o, cs_n_o, xfer_cs_n_o, wr_n_o, xfer_n_o;
  logic [7:0] data_o;

  always #4 clk_i = ~clk_i;

  dac_wr_seq #(.SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .mode_i(mode_i),
    .valid_i(valid_i), .ready_o(ready_o), .ext_upd_i(ext_upd_i),
    .data_o(data_o), .addr0_o(addr0_o), .bsel_o(bsel_o), .cs_n_o(cs_n_o),
    .xfer_cs_n_o(xfer_cs_n_o), .wr_n_o(wr_n_o), .xfer_n_o(xfer_n_o)
  );

  int checks = 0, errors = 0;

  // write / transfer log built at the ports
  int nw, nx, low_run, xlow_run, setup_run, busy_viol;
  logic [7:0] w_data[8];
  bit w_a0[8], w_bs[8], w_cs[8], w_xcs[8], w_xf[8], w_hold[8], x_wr[8];
  int w_width[8], w_setup[8], x_width[8], x_after[8];
  logic pw_q = 1, px_q = 1;
  logic [7:0] pdata = '0;

  task automatic clear_log();
    nw = 0; nx = 0; busy_viol = 0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ready_o && (!wr_n_o || !xfer_n_o)) busy_viol++;
      if (!wr_n_o && pw_q && nw < 8) begin
        w_data[nw] = data_o; w_a0[nw] = addr0_o; w_bs[nw] = bsel_o;
        w_cs[nw] = cs_n_o; w_xcs[nw] = xfer_cs_n_o; w_xf[nw] = xfer_n_o;
        w_setup[nw] = setup_run; low_run = 1;
      end else if (!wr_n_o) low_run++;
      if (wr_n_o && !pw_q && nw < 8) begin
        w_width[nw] = low_run;
        w_hold[nw] = (data_o == w_data[nw]) && (cs_n_o == w_cs[nw]) &&
                     (xfer_cs_n_o == w_xcs[nw]);
        nw++;
      end
      if (!xfer_n_o && px_q && nx < 8) begin
        x_wr[nx] = wr_n_o; x_after[nx] = nw; xlow_run = 1;
      end else if (!xfer_n_o) xlow_run++;
      if (xfer_n_o && !px_q && nx < 8) begin
        x_width[nx] = xlow_run; nx++;
      end
      if (wr_n_o) begin
        if (!cs_n_o || !xfer_cs_n_o) setup_run = (data_o == pdata) ? setup_run + 1 : 1;
        else setup_run = 0;
      end
      pw_q = wr_n_o; px_q = xfer_n_o; pdata = data_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] w, input logic [1:0] m);
    @(negedge clk_i);
    word_i = w; mode_i = m; valid_i = 1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 0; word_i = ~w; mode_i = ~m;  // captured already (R8)
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk_i);
    while (!ready_o && n < 500) begin @(negedge clk_i); n++; end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic pulse_ext();
    @(negedge clk_i); ext_upd_i = 1;
    @(negedge clk_i); ext_upd_i = 0;
  endtask

  task automatic check_bytes(input logic [9:0] w, input int base);
    chk(w_data[base] == w[9:2], "R2 first byte", int'(w_data[base]), int'(w[9:2]));
    chk(!w_a0[base] && w_bs[base], "R2 first addr0/bsel", {w_a0[base], w_bs[base]}, 1);
    chk(w_data[base+1] == {w[1:0], 6'b0}, "R2 second byte", int'(w_data[base+1]),
        int'({w[1:0], 6'b0}));
    chk(w_a0[base+1] && !w_bs[base+1], "R2 second addr0/bsel",
        {w_a0[base+1], w_bs[base+1]}, 2);
    for (int i = base; i < base + 2; i++) begin
      chk(w_width[i] == PW, "R3 strobe width", w_width[i], PW);
      chk(w_setup[i] >= SU, "R3 setup cycles", w_setup[i], SU);
      chk(w_hold[i], "R3 hold after rise", w_hold[i], 1);
    end
  endtask

  task automatic t_reset();
    chk(ready_o && cs_n_o && xfer_cs_n_o && wr_n_o && xfer_n_o, "R1 reset outputs",
        {ready_o, cs_n_o, xfer_cs_n_o, wr_n_o, xfer_n_o}, 31);
  endtask

  task automatic t_auto(input logic [9:0] w, input logic [1:0] m);
    clear_log();
    send(w, m);
    wait_idle();
    chk(nw == 2, "R4 write count", nw, 2);
    check_bytes(w, 0);
    chk(w_xf[0] && !w_xf[1], "R4 xfer with second write", {w_xf[0], w_xf[1]}, 2);
    chk(nx == 1 && x_width[0] == PW, "R4 single xfer pulse", nx * 10 + x_width[0], 10 + PW);
    chk(busy_viol == 0, "R8 ready low while busy", busy_viol, 0);
  endtask

  task automatic t_proc(input logic [9:0] w);
    clear_log();
    send(w, 2'd1);
    wait_idle();
    chk(nw == 3, "R5 write count", nw, 3);
    check_bytes(w, 0);
    chk(!w_cs[0] && !w_cs[1] && w_xcs[0] && w_xcs[1] && w_xf[0] && w_xf[1],
        "R5 data writes no xfer", {w_cs[0], w_cs[1], w_xf[0], w_xf[1]}, 3);
    chk(w_cs[2] && !w_xcs[2] && !w_xf[2], "R5 third write selects",
        {w_cs[2], w_xcs[2], w_xf[2]}, 4);
    chk(nx == 1 && x_after[0] == 2, "R5 xfer on third write", nx * 10 + x_after[0], 12);
  endtask

  task automatic t_ext_late(input logic [9:0] w);
    clear_log();
    send(w, 2'd2);
    repeat (60) @(negedge clk_i);
    chk(nw == 2 && nx == 0, "R6 no xfer before strobe", nw * 10 + nx, 20);
    chk(!ready_o, "R6 still busy waiting", ready_o, 0);
    check_bytes(w, 0);
    pulse_ext();
    wait_idle();
    chk(nx == 1 && x_wr[0] && x_width[0] == PW, "R6 xfer pulse after strobe",
        nx * 100 + x_wr[0] * 10 + x_width[0], 110 + PW);
  endtask

  task automatic t_ext_early(input logic [9:0] w);
    clear_log();
    send(w, 2'd2);
    repeat (2) @(negedge clk_i);
    chk(nw == 0 && !wr_n_o, "R7 strobe placed during first write", nw * 10 + wr_n_o, 0);
    pulse_ext();
    wait_idle();
    chk(nw == 2 && nx == 1 && x_after[0] == 2, "R7 early strobe kept",
        nw * 100 + nx * 10 + x_after[0], 212);
  endtask

  task automatic t_idle_ext(input logic [9:0] w);
    clear_log();
    pulse_ext();
    repeat (3) @(negedge clk_i);
    send(w, 2'd2);
    repeat (60) @(negedge clk_i);
    chk(nx == 0 && !ready_o, "R9 idle strobe discarded", nx * 10 + ready_o, 0);
    pulse_ext();
    wait_idle();
    chk(nx == 1, "R9 xfer after fresh strobe", nx, 1);
  endtask

  task automatic t_b2b(input logic [9:0] a, input logic [9:0] b);
    clear_log();
    @(negedge clk_i);
    word_i = a; mode_i = 2'd0; valid_i = 1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    word_i = b;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 0; word_i = '0;
    wait_idle();
    chk(nw == 4 && nx == 2, "R8 two back-to-back words", nw * 10 + nx, 42);
    chk(x_after[0] == 1 && x_after[1] == 3, "R8 second word after first xfer",
        x_after[0] * 10 + x_after[1], 13);
    check_bytes(a, 0);
    check_bytes(b, 2);
    chk(busy_viol == 0, "R8 ready low while busy", busy_viol, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_auto(10'h2A5, 2'd0);
    t_auto(10'h3FF, 2'd0);
    t_auto(10'h103, 2'd3);
    t_proc(10'h1C6);
    t_proc(10'h000);
    t_ext_late(10'h27E);
    t_ext_early(10'h0D9);
    t_idle_ext(10'h355);
    t_b2b(10'h081, 10'h3C2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule